// File: doc/BRIEF.md
# SDR SDRAM Command Controller

This block turns single-word host reads and writes into the command stream of a four-bank single-data-rate SDRAM. A flat host address is split into column, bank and row. Each access opens its row with ACTIVE, issues one READ or WRITE, and closes the bank with a single-bank PRECHARGE. So between host transactions every bank is idle. A periodic refresh scheduler raises a pending flag. The flag is served with AUTO REFRESH from the idle state and wins over a waiting host request.

After reset the controller runs the power-up sequence before it accepts traffic. It sends NOPs for a programmable settling delay, then PRECHARGE of all banks, then two AUTO REFRESH commands each followed by the refresh-cycle wait, then LOAD MODE REGISTER with a burst length of one and the programmed CAS latency. All waits come from one shared down-counter. Read data is captured from the device bus CAS_LAT cycles after READ and is returned as a one-cycle pulse.

The state machine has these states:
- Power-up: PWR_WAIT, INIT_PRE, INIT_PRE_WAIT, INIT_REF, INIT_REF_WAIT, INIT_LMR, INIT_LMR_WAIT.
- Service: IDLE, REF, REF_WAIT, ACT, ACT_WAIT.
- Read: READ, READ_WAIT, READ_CAP.
- Write: WRITE, WRITE_REC.
- Close: PRE, PRE_WAIT.

Its transitions are:
- PWR_WAIT→INIT_PRE when the settling count expires.
- INIT_PRE→INIT_PRE_WAIT→INIT_REF.
- INIT_REF→INIT_REF_WAIT, which returns to INIT_REF after the first refresh and moves on to INIT_LMR after the second.
- INIT_LMR→INIT_LMR_WAIT→IDLE.
- IDLE→REF when a refresh is pending, else IDLE→ACT when a request is accepted.
- REF→REF_WAIT→IDLE.
- ACT→ACT_WAIT, then on to READ or to WRITE.
- READ→READ_WAIT→READ_CAP→PRE.
- WRITE→WRITE_REC→PRE.
- PRE→PRE_WAIT→IDLE.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: Host address bits [COL_W-1:0] give the column, the next BANK_W bits give the bank and the top ROW_W bits give the row. ACTIVE carries the bank on sd_ba and the row on sd_addr. READ and WRITE carry the same bank, with the column in the low sd_addr bits and sd_addr[10] low.
- R2: Commands are encoded on {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} as NOP=0111, ACTIVE=0011, READ=0101, WRITE=0100, PRECHARGE=0010, AUTO REFRESH=0001, LOAD MODE=0000. No other code is ever driven.
- R3: During reset and for INIT_WAIT cycles after it, only NOP is driven and req_ready is low. The first commands then follow in this order: PRECHARGE with sd_addr[10]=1, AUTO REFRESH, AUTO REFRESH, LOAD MODE. Consecutive refresh-related commands are at least T_RFC cycles apart. req_ready stays low until LOAD MODE has been issued.
- R4: The LOAD MODE word on sd_addr has bits [2:0]=000 (burst of one), bit 3=0, bits [6:4]=CAS_LAT and all higher bits 0, with sd_ba=0.
- R5: READ or WRITE to a bank is issued exactly T_RCD cycles after the ACTIVE that opened it, and only to an open bank.
- R6: Read data is sampled from sd_dq_in CAS_LAT cycles after READ. rd_valid is a one-cycle pulse with that data, first seen 1+T_RCD+CAS_LAT clock edges after the edge that accepted the request.
- R7: sd_dq_oe is high only in the WRITE cycle, with the request data on sd_dq_out. The PRECHARGE that follows a WRITE comes T_WR+1 cycles after it, so there are T_WR NOP cycles of write recovery.
- R8: Every access is closed by a single-bank PRECHARGE (sd_addr[10]=0) to the open bank. No ACTIVE goes to a bank sooner than T_RP cycles after its precharge, or sooner than T_RFC cycles after AUTO REFRESH.
- R9: A refresh becomes pending every REF_PERIOD cycles. It is issued from idle only when all banks are closed, and before any waiting host request, so consecutive refreshes are never much more than REF_PERIOD apart.
- R10: req_ready is high only in idle with no refresh pending. A request is taken on a rising edge with req_valid and req_ready both high.
- R11: A read returns the data of the most recent write to the same host address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, shared with the device |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+BANK_W+COL_W | Flat word address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request can be taken this cycle |
| rd_valid | output | 1 | Read data pulse |
| rd_data | output | DATA_W | Read data |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ROW_W | Multiplexed row/column/mode address |
| sd_dq_out | output | DATA_W | Data to the device |
| sd_dq_oe | output | 1 | Drive enable for sd_dq_out |
| sd_dq_in | input | DATA_W | Data from the device |

## Verification
The hardest case to reach is a refresh that falls due while a host request is already waiting at the port or a transaction is partway through. The bench must then see the refresh delayed to idle, issued with every bank closed, and served ahead of the waiting request. The bench shortens REF_PERIOD and keeps requests back to back, random reads and writes over a pool of boundary and random addresses. Refresh deadlines therefore land at every phase of a transaction. The behavioural device model checks each command's spacing and bank state in the cycle it appears.

// File: rtl/sdram_ctrl_pkg.sv
package sdram_ctrl_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    typedef enum logic [4:0] {
        ST_PWR_WAIT,
        ST_INIT_PRE,
        ST_INIT_PRE_WAIT,
        ST_INIT_REF,
        ST_INIT_REF_WAIT,
        ST_INIT_LMR,
        ST_INIT_LMR_WAIT,
        ST_IDLE,
        ST_REF,
        ST_REF_WAIT,
        ST_ACT,
        ST_ACT_WAIT,
        ST_READ,
        ST_READ_WAIT,
        ST_READ_CAP,
        ST_WRITE,
        ST_WRITE_REC,
        ST_PRE,
        ST_PRE_WAIT
    } ctrl_state_e;

endpackage

// File: rtl/sdram_addr_map.sv
module sdram_addr_map #(
    parameter int COL_W  = 8,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12,
    localparam int ADDR_W = ROW_W + BANK_W + COL_W
) (
    input  logic [ADDR_W-1:0] flat_addr,
    output logic [COL_W-1:0]  col,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row
);
    assign col  = flat_addr[COL_W-1:0];
    assign bank = flat_addr[COL_W +: BANK_W];
    assign row  = flat_addr[COL_W+BANK_W +: ROW_W];
endmodule

// File: rtl/sdram_wait_timer.sv
module sdram_wait_timer #(
    parameter int CNT_W       = 8,
    parameter int RESET_COUNT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= CNT_W'(RESET_COUNT);
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    // R5: a running count never stalls
    a_r5_timer_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
    parameter int PERIOD = 1560,
    localparam int CW = $clog2(PERIOD + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic pending
);
    logic [CW-1:0] cnt_q;
    logic          tick;

    assign tick = (cnt_q == CW'(PERIOD - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pending <= 1'b0;
        end else begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
            if (tick)     pending <= 1'b1;
            else if (ack) pending <= 1'b0;
        end
    end

    // R9: a due refresh is not dropped before it is served
    a_r9_pending_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !ack) |=> pending);
endmodule

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
    import sdram_ctrl_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int COL_W      = 8,
    parameter int BANK_W     = 2,
    parameter int ROW_W      = 12,
    parameter int CAS_LAT    = 3,
    parameter int T_RCD      = 3,
    parameter int T_RP       = 3,
    parameter int T_WR       = 2,
    parameter int T_RFC      = 10,
    parameter int T_MRD      = 2,
    parameter int INIT_WAIT  = 10000,
    parameter int REF_PERIOD = 1560,
    localparam int ADDR_W    = ROW_W + BANK_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ROW_W-1:0]  sd_addr,
    output logic [DATA_W-1:0] sd_dq_out,
    output logic              sd_dq_oe,
    input  logic [DATA_W-1:0] sd_dq_in
);
    localparam int NUM_BANKS = 1 << BANK_W;
    localparam int CNT_W = $clog2(INIT_WAIT + T_RFC + T_RP + T_RCD + CAS_LAT + T_WR + T_MRD + 1);
    localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT << 4);

    ctrl_state_e state_q, state_d;
    sd_cmd_e     cmd;

    logic [COL_W-1:0]  map_col,  col_q;
    logic [BANK_W-1:0] map_bank, bank_q;
    logic [ROW_W-1:0]  map_row,  row_q;
    logic              write_q;
    logic [DATA_W-1:0] wdata_q;
    logic              init_ref2_q;

    logic             tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;
    logic             ref_pending, ref_ack, accept;

    sdram_addr_map #(.COL_W(COL_W), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_map (
        .flat_addr(req_addr), .col(map_col), .bank(map_bank), .row(map_row)
    );

    sdram_wait_timer #(.CNT_W(CNT_W), .RESET_COUNT(INIT_WAIT - 1)) u_wait (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    sdram_refresh_timer #(.PERIOD(REF_PERIOD)) u_refresh (
        .clk(clk), .rst_n(rst_n), .ack(ref_ack), .pending(ref_pending)
    );

    assign req_ready = (state_q == ST_IDLE) && !ref_pending;
    assign accept    = req_ready && req_valid;
    assign ref_ack   = (state_q == ST_REF);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PWR_WAIT;
        else        state_q <= state_d;
    end

    // next state and wait loads
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_PWR_WAIT:      if (tmr_done) state_d = ST_INIT_PRE;
            ST_INIT_PRE: begin
                state_d = ST_INIT_PRE_WAIT; tmr_load = 1'b1; tmr_val = CNT_W'(T_RP - 2);
            end
            ST_INIT_PRE_WAIT: if (tmr_done) state_d = ST_INIT_REF;
            ST_INIT_REF: begin
                state_d = ST_INIT_REF_WAIT; tmr_load = 1'b1; tmr_val = CNT_W'(T_RFC - 2);
            end
            ST_INIT_REF_WAIT: if (tmr_done) state_d = init_ref2_q ? ST_INIT_LMR : ST_INIT_REF;
            ST_INIT_LMR: begin
                state_d = ST_INIT_LMR_WAIT; tmr_load = 1'b1; tmr_val = CNT_W'(T_MRD - 2);
            end
            ST_INIT_LMR_WAIT: if (tmr_done) state_d = ST_IDLE;
            ST_IDLE: begin
                if (ref_pending) state_d = ST_REF;
                else if (accept) state_d = ST_ACT;
            end
            ST_REF: begin
                state_d = ST_REF_WAIT; tmr_load = 1'b1; tmr_val = CNT_W'(T_RFC - 2);
            end
            ST_REF_WAIT:      if (tmr_done) state_d = ST_IDLE;
            ST_ACT: begin
                state_d = ST_ACT_WAIT; tmr_load = 1'b1; tmr_val = CNT_W'(T_RCD - 2);
            end
            ST_ACT_WAIT:      if (tmr_done) state_d = write_q ? ST_WRITE : ST_READ;
            ST_READ: begin
                state_d = ST_READ_WAIT; tmr_load = 1'b1; tmr_val = CNT_W'(CAS_LAT - 2);
            end
            ST_READ_WAIT:     if (tmr_done) state_d = ST_READ_CAP;
            ST_READ_CAP:      state_d = ST_PRE;
            ST_WRITE: begin
                state_d = ST_WRITE_REC; tmr_load = 1'b1; tmr_val = CNT_W'(T_WR - 1);
            end
            ST_WRITE_REC:     if (tmr_done) state_d = ST_PRE;
            ST_PRE: begin
                state_d = ST_PRE_WAIT; tmr_load = 1'b1; tmr_val = CNT_W'(T_RP - 2);
            end
            ST_PRE_WAIT:      if (tmr_done) state_d = ST_IDLE;
            default:          state_d = ST_PWR_WAIT;
        endcase
    end

    // command outputs
    always_comb begin
        cmd      = CMD_NOP;
        sd_ba    = '0;
        sd_addr  = '0;
        sd_dq_oe = 1'b0;
        unique case (state_q)
            ST_INIT_PRE: begin cmd = CMD_PRE; sd_addr[10] = 1'b1; end
            ST_INIT_REF, ST_REF: cmd = CMD_REF;
            ST_INIT_LMR: begin cmd = CMD_LMR; sd_addr = MODE_WORD; end
            ST_ACT:      begin cmd = CMD_ACT; sd_ba = bank_q; sd_addr = row_q; end
            ST_READ:     begin cmd = CMD_RD;  sd_ba = bank_q; sd_addr[COL_W-1:0] = col_q; end
            ST_WRITE: begin
                cmd = CMD_WR; sd_ba = bank_q; sd_addr[COL_W-1:0] = col_q; sd_dq_oe = 1'b1;
            end
            ST_PRE:      begin cmd = CMD_PRE; sd_ba = bank_q; end
            default:     cmd = CMD_NOP;
        endcase
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    assign sd_dq_out = wdata_q;

    // request latch, init bookkeeping and read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0; bank_q <= '0; row_q <= '0; write_q <= 1'b0; wdata_q <= '0;
            init_ref2_q <= 1'b0;
            rd_valid <= 1'b0; rd_data <= '0;
        end else begin
            if (accept) begin
                col_q <= map_col; bank_q <= map_bank; row_q <= map_row;
                write_q <= req_write; wdata_q <= req_wdata;
            end
            if (state_q == ST_INIT_REF_WAIT && tmr_done) init_ref2_q <= 1'b1;
            rd_valid <= (state_q == ST_READ_CAP);
            if (state_q == ST_READ_CAP) rd_data <= sd_dq_in;
        end
    end

    // ---- bank tracker watching the command pins, used only by assertions ----
    logic [NUM_BANKS-1:0] open_q;
    logic                 init_done_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= '0; init_done_q <= 1'b0;
        end else begin
            if (cmd == CMD_ACT) open_q[sd_ba] <= 1'b1;
            if (cmd == CMD_PRE) begin
                if (sd_addr[10]) open_q <= '0;
                else             open_q[sd_ba] <= 1'b0;
            end
            if (cmd == CMD_LMR) init_done_q <= 1'b1;
        end
    end

    a_r9_refresh_all_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REF) |-> (open_q == '0));
    a_r8_act_to_closed_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT) |-> !open_q[sd_ba]);
    a_r5_column_to_open_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_RD || cmd == CMD_WR) |-> open_q[sd_ba]);
    a_r6_rd_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    a_r7_write_recovery_nop: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_WR) |=> (cmd == CMD_NOP));
    a_r3_no_ready_before_mode: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done_q |-> !req_ready);
endmodule

// File: tb/sdram_cmd_ctrl_tb_top.sv
module sdram_cmd_ctrl_tb_top;
    localparam int DW = 16, CW = 8, BW = 2, RW = 12, AW = RW + BW + CW;
    localparam int CL = 2, TRCD = 2, TRP = 2, TWR = 2, TRFC = 6, TMRD = 2;
    localparam int IWAIT = 40, RPER = 300, SLACK = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rd_valid, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [DW-1:0] rd_data, sd_dq_out, sd_dq_in;
    logic [BW-1:0] sd_ba;
    logic [RW-1:0] sd_addr;

    sdram_cmd_ctrl #(
        .DATA_W(DW), .COL_W(CW), .BANK_W(BW), .ROW_W(RW), .CAS_LAT(CL), .T_RCD(TRCD),
        .T_RP(TRP), .T_WR(TWR), .T_RFC(TRFC), .T_MRD(TMRD), .INIT_WAIT(IWAIT), .REF_PERIOD(RPER)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
        .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
    );

    int n_tests = 0, n_fail = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [CW-1:0] f_col(input logic [AW-1:0] a);  return a[CW-1:0]; endfunction
    function automatic logic [BW-1:0] f_bank(input logic [AW-1:0] a); return a[CW +: BW]; endfunction
    function automatic logic [RW-1:0] f_row(input logic [AW-1:0] a);  return a[CW+BW +: RW]; endfunction

    // ---------------- behavioural device and protocol monitor ----------------
    logic [3:0]    cmd;
    assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    int            cyc = 0, rel_cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [DW-1:0] dev_mem [logic [AW-1:0]];
    logic [DW-1:0] pipe [4];
    assign sd_dq_in = pipe[CL];

    logic [AW-1:0] exp_addr = '0, act_addr = '0;
    bit            bopen [4];
    logic [RW-1:0] brow [4];
    int            act_cyc [4], pre_cyc [4];
    int            last_ref = -1000, last_wr = -1000, init_step = 0, ref_cnt = 0;
    bit            last_was_wr = 1'b0;

    initial for (int b = 0; b < 4; b++) begin bopen[b] = 0; pre_cyc[b] = -1000; act_cyc[b] = 0; brow[b] = '0; end

    always @(negedge clk) begin
        logic [DW-1:0] rd_word;
        rd_word = '0;
        if (rst_n) begin
            if (sd_dq_oe && cmd != 4'b0100) check(0, "R7 oe outside WRITE", cmd, 4'b0100);
            case (cmd)
                4'b0111: ;
                4'b0011: begin
                    check(!bopen[sd_ba], "R8 ACTIVE to open bank", bopen[sd_ba], 0);
                    check(cyc - pre_cyc[sd_ba] >= TRP, "R8 ACTIVE after PRE gap", cyc - pre_cyc[sd_ba], TRP);
                    check(cyc - last_ref >= TRFC, "R8 ACTIVE after REF gap", cyc - last_ref, TRFC);
                    check(sd_ba == f_bank(exp_addr), "R1 ACTIVE bank", sd_ba, f_bank(exp_addr));
                    check(sd_addr == f_row(exp_addr), "R1 ACTIVE row", sd_addr, f_row(exp_addr));
                    act_addr = exp_addr;
                    bopen[sd_ba] = 1; brow[sd_ba] = sd_addr; act_cyc[sd_ba] = cyc;
                end
                4'b0101, 4'b0100: begin
                    check(bopen[sd_ba], "R5 column cmd to closed bank", bopen[sd_ba], 1);
                    check(cyc - act_cyc[sd_ba] == TRCD, "R5 ACTIVE to column delay", cyc - act_cyc[sd_ba], TRCD);
                    check(sd_ba == f_bank(act_addr), "R1 column bank", sd_ba, f_bank(act_addr));
                    check(sd_addr[CW-1:0] == f_col(act_addr), "R1 column", sd_addr[CW-1:0], f_col(act_addr));
                    check(sd_addr[10] == 1'b0, "R1 A10 on column cmd", sd_addr[10], 0);
                    if (cmd == 4'b0100) begin
                        check(sd_dq_oe == 1'b1, "R7 oe in WRITE", sd_dq_oe, 1);
                        dev_mem[{sd_ba, brow[sd_ba], sd_addr[CW-1:0]}] = sd_dq_out;
                        last_wr = cyc; last_was_wr = 1;
                    end else begin
                        if (dev_mem.exists({sd_ba, brow[sd_ba], sd_addr[CW-1:0]}))
                            rd_word = dev_mem[{sd_ba, brow[sd_ba], sd_addr[CW-1:0]}];
                        else rd_word = 16'hDEAD;
                        last_was_wr = 0;
                    end
                end
                4'b0010: begin
                    if (sd_addr[10]) begin
                        if (init_step == 0) begin
                            check(cyc - rel_cyc >= IWAIT, "R3 settle wait", cyc - rel_cyc, IWAIT);
                            init_step = 1;
                        end else check(0, "R3 unexpected all-bank PRE", init_step, 0);
                        for (int b = 0; b < 4; b++) begin bopen[b] = 0; pre_cyc[b] = cyc; end
                    end else begin
                        check(bopen[sd_ba], "R8 PRE to open bank", bopen[sd_ba], 1);
                        if (last_was_wr)
                            check(cyc - last_wr == TWR + 1, "R7 write recovery", cyc - last_wr, TWR + 1);
                        bopen[sd_ba] = 0; pre_cyc[sd_ba] = cyc;
                    end
                end
                4'b0001: begin
                    check(!(bopen[0] | bopen[1] | bopen[2] | bopen[3]), "R9 REF with open bank", 1, 0);
                    check(req_ready == 1'b0, "R10 ready during REF", req_ready, 0);
                    check(cyc - last_ref >= TRFC, "R3 REF spacing", cyc - last_ref, TRFC);
                    if (init_step < 4) begin
                        check(init_step == 1 || init_step == 2, "R3 init order REF", init_step, 1);
                        init_step++;
                    end else begin
                        check(cyc - last_ref <= RPER + SLACK, "R9 refresh gap", cyc - last_ref, RPER + SLACK);
                        ref_cnt++;
                    end
                    last_ref = cyc;
                end
                4'b0000: begin
                    check(init_step == 3, "R3 init order LMR", init_step, 3);
                    check(cyc - last_ref >= TRFC, "R3 LMR after REF", cyc - last_ref, TRFC);
                    check(sd_addr == 12'(CL << 4), "R4 mode word", sd_addr, 12'(CL << 4));
                    check(sd_ba == '0, "R4 mode bank", sd_ba, 0);
                    init_step = 4;
                end
                default: check(0, "R2 illegal command code", cmd, 4'b0111);
            endcase
        end
        pipe[3] <= pipe[2]; pipe[2] <= pipe[1]; pipe[1] <= pipe[0]; pipe[0] <= rd_word;
    end

    // ---------------- host side ----------------
    logic [DW-1:0] ref_mem [logic [AW-1:0]];

    task automatic host_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        int k;
        @(negedge clk);
        exp_addr = a; req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        if (wr) ref_mem[a] = d;
        else begin
            k = 1;
            while (!rd_valid && k < 60) begin @(negedge clk); k++; end
            check(k == TRCD + CL + 2, "R6 read return edge", k, TRCD + CL + 2);
            check(rd_data == ref_mem[a], "R11 read data", rd_data, ref_mem[a]);
            @(negedge clk);
            check(!rd_valid, "R6 single pulse", rd_valid, 0);
        end
    endtask

    logic [AW-1:0] pool [16];

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 4; i++) pipe[i] = '0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(cmd == 4'b0111, "R3 NOP in reset", cmd, 4'b0111);
            check(!req_ready && !rd_valid && !sd_dq_oe, "R3 outputs idle in reset", {req_ready, rd_valid, sd_dq_oe}, 0);
        end
        rst_n = 1; rel_cyc = cyc;
        while (!req_ready) @(negedge clk);
        check(init_step == 4, "R3 init complete before ready", init_step, 4);
        check(cyc - rel_cyc >= IWAIT + TRP + 2 * TRFC, "R10 ready low through init", cyc - rel_cyc, IWAIT);

        // directed: overwrite, bank separation, address extremes
        host_op(1, 22'h000000, 16'h1111);
        host_op(1, 22'h000000, 16'h2222);
        host_op(0, 22'h000000, 0);
        for (int b = 0; b < 4; b++) host_op(1, {12'hABC, 2'(b), 8'h5A}, 16'hB000 + 16'(b));
        for (int b = 3; b >= 0; b--) host_op(0, {12'hABC, 2'(b), 8'h5A}, 0);
        host_op(1, '1, 16'hFFFE);
        host_op(1, {12'hFFF, 2'b00, 8'h00}, 16'h0F0F);
        host_op(1, {12'h000, 2'b00, 8'hFF}, 16'hF0F0);
        host_op(0, '1, 0);
        host_op(0, {12'hFFF, 2'b00, 8'h00}, 0);
        host_op(0, {12'h000, 2'b00, 8'hFF}, 0);

        // random traffic over a pool, refresh deadlines land at any phase
        pool[0] = '0; pool[1] = '1; pool[2] = {12'hFFF, 10'h0}; pool[3] = {12'h0, 2'b11, 8'hFF};
        for (int i = 4; i < 16; i++) pool[i] = AW'($urandom);
        for (int n = 0; n < 400; n++) begin
            logic [AW-1:0] a;
            a = pool[$urandom % 16];
            if (!ref_mem.exists(a) || ($urandom % 2)) host_op(1, a, DW'($urandom));
            else host_op(0, a, 0);
        end
        repeat (20) @(negedge clk);
        check(ref_cnt >= (cyc - rel_cyc) / RPER - 2, "R9 refresh count", ref_cnt, (cyc - rel_cyc) / RPER - 2);
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule